// File: doc/BRIEF.md
# Offset-Based Tick Timer

This block is a 64-bit time-base register for a processor core. It does not hold the visible count directly. A free-running 63-bit counter advances by one on each increment strobe from the core. A stored 63-bit offset is added to that counter to form the visible count. Bit 63 of the register is held in its own flip-flop, apart from the count.

A software write never touches the running counter. It stores the written value minus the current counter as the new offset, and it stores the written top bit on its own. A read returns the top bit, count bits 62 down to 2, and two zero low bits. Two register selects, the plain tick and the system tick, alias the same state.

There are three compare registers. Each one raises its own sticky interrupt when its low 63 bits equal the current count, unless its bit 63 disables it. The interrupt stays set until software clears it.

Top module: `tick_offset_timer`

## Requirements
- R1: While reset is held, rd_data and irq are zero. After reset the state is: top bit 1, count 0, all compare registers 0. A read of select 0 then returns 64'h8000_0000_0000_0000.
- R2: Each cycle with tick_inc high adds one to the 63-bit count, which wraps from 2^63-1 to 0 and leaves the top bit alone. With no write and no strobe, the count holds.
- R3: A write to select 0 or 1 makes the count equal wr_data[62:0] and the top bit equal wr_data[63]. If tick_inc is also high in that cycle, the count becomes wr_data[62:0]+1.
- R4: rd_data is registered. It shows, one cycle after rd_sel is applied, the state held before that clock edge. For select 0 or 1 it reads {top bit, count[62:2], 2'b00}.
- R5: Selects 0 (tick) and 1 (system tick) address one shared state. A write through either one is seen by a read through the other.
- R6: Selects 2, 3 and 4 are the three compare registers, indexed 0, 1 and 2. Each is written and read back as a full 64-bit value.
- R7: When compare register k has bit 63 clear and bits 62:0 equal the count, irq[k] is 1 from the next cycle on.
- R8: A compare register whose bit 63 is set never raises its irq bit.
- R9: irq_clr[k] high clears irq[k] at the next edge. A match in the same cycle wins, and the bit stays set.
- R10: A write to selects 5 to 7 changes no state, and a read of them returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_inc | input | 1 | Count increment strobe from the core |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 64 | Write value |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 64 | Registered read value |
| irq_clr | input | 3 | Per-compare interrupt clear |
| irq | output | 3 | Sticky compare-match interrupts |

## Verification
The assertions assume that the select, data and strobe inputs are always at a known level, and that a write and an increment in the same cycle combine as R3 states. They place no limit on the values themselves. The random stimulus therefore drives every select code, including the unused ones, and every data pattern. Compare values are steered to within a few counts of the modelled count, so that matches, masked matches and clear-versus-match collisions all occur. Directed steps cover the counter wrap and the masking of the low read bits, which random data would seldom reach.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int SELW     = 3;
  localparam int NCMP     = 3;
  localparam int CMP_BASE = 2;

  typedef enum logic [SELW-1:0] {
    RS_TICK  = 3'd0,
    RS_STICK = 3'd1,
    RS_TCMP  = 3'd2,
    RS_SCMP  = 3'd3,
    RS_HCMP  = 3'd4
  } tsel_e;

  function automatic logic is_count_sel(input logic [SELW-1:0] s);
    return (s == RS_TICK) || (s == RS_STICK);
  endfunction
endpackage

// File: rtl/tick_offset_core.sv
module tick_offset_core #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inc,
  input  logic           wr,
  input  logic [W-1:0]   wr_data,
  output logic [W-2:0]   cur_val,
  output logic           top_q
);
  localparam int VW = W - 1;

  logic [VW-1:0] cnt_q;
  logic [VW-1:0] off_q;

  assign cur_val = cnt_q + off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      off_q <= '0;
      top_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + VW'(inc);
      if (wr) begin
        off_q <= wr_data[VW-1:0] - cnt_q;
        top_q <= wr_data[W-1];
      end
    end
  end

  assert_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr && inc) |=> (cur_val == $past(cur_val) + VW'(1)) && $stable(top_q));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr && !inc) |=> $stable(cur_val) && $stable(top_q));
  assert_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cur_val == $past(wr_data[VW-1:0]) + VW'($past(inc)))
           && (top_q == $past(wr_data[W-1])));
endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-2:0] cur_val,
  input  logic         clr,
  output logic [W-1:0] cmp_q,
  output logic         irq_q
);
  logic hit;

  assign hit = !cmp_q[W-1] && (cmp_q[W-2:0] == cur_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr) cmp_q <= wr_data;
      if (hit)      irq_q <= 1'b1;
      else if (clr) irq_q <= 1'b0;
    end
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr) |=> irq_q);
  assert_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (cmp_q[W-1] && !irq_q) |=> !irq_q);
  assert_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(cmp_q[W-2:0] == cur_val));
endmodule

// File: rtl/tick_offset_timer.sv
module tick_offset_timer
  import tick_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_inc,
  input  logic                wr_en,
  input  logic [SELW-1:0]     wr_sel,
  input  logic [W-1:0]        wr_data,
  input  logic [SELW-1:0]     rd_sel,
  output logic [W-1:0]        rd_data,
  input  logic [NCMP-1:0]     irq_clr,
  output logic [NCMP-1:0]     irq
);
  logic [W-2:0] cur_val;
  logic         top_q;
  logic [W-1:0] cmp_arr [NCMP];
  logic [W-1:0] rd_next;

  tick_offset_core #(.W(W)) core_i (
    .clk(clk), .rst(rst), .inc(tick_inc),
    .wr(wr_en && is_count_sel(wr_sel)),
    .wr_data(wr_data), .cur_val(cur_val), .top_q(top_q)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    localparam logic [SELW-1:0] MYSEL = SELW'(CMP_BASE + g);
    tick_cmp_unit #(.W(W)) cmp_i (
      .clk(clk), .rst(rst),
      .wr(wr_en && (wr_sel == MYSEL)),
      .wr_data(wr_data), .cur_val(cur_val), .clr(irq_clr[g]),
      .cmp_q(cmp_arr[g]), .irq_q(irq[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (is_count_sel(rd_sel)) begin
      rd_next = {top_q, cur_val[W-2:2], 2'b00};
    end
    for (int k = 0; k < NCMP; k++) begin
      if (rd_sel == SELW'(CMP_BASE + k)) rd_next = cmp_arr[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assert_lowbits_R4: assert property (@(posedge clk) disable iff (rst)
    is_count_sel(rd_sel) |=> (rd_data[1:0] == 2'b00));
  assert_unused_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_sel >= SELW'(CMP_BASE + NCMP)) |=> (rd_data == '0));
  assert_alias_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == RS_STICK) |=> (rd_data[W-1] == $past(top_q)));
endmodule

// File: tb/tick_offset_timer_tb.sv
`timescale 1ns/1ps
module tick_offset_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick_inc;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [63:0] wr_data;
  logic [2:0]  rd_sel;
  logic [63:0] rd_data;
  logic [2:0]  irq_clr;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [62:0] m_val;
  logic        m_top;
  logic [63:0] m_cmp [3];
  logic [2:0]  m_irq;

  always #2.5 clk = ~clk;

  tick_offset_timer dut_i (
    .clk(clk), .rst(rst), .tick_inc(tick_inc), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_clr(irq_clr), .irq(irq)
  );

  function automatic logic [63:0] exp_read(input logic [2:0] s);
    if (s <= 3'd1) return {m_top, m_val[62:2], 2'b00};
    if (s <= 3'd4) return m_cmp[s - 3'd2];
    return 64'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic inc, input logic wr, input logic [2:0] ws,
                      input logic [63:0] wd, input logic [2:0] rs,
                      input logic [2:0] clr, input string tag);
    logic [63:0] erd;
    logic [2:0]  hit;
    tick_inc = inc; wr_en = wr; wr_sel = ws; wr_data = wd; rd_sel = rs; irq_clr = clr;
    erd = exp_read(rs);
    for (int k = 0; k < 3; k++)
      hit[k] = !m_cmp[k][63] && (m_cmp[k][62:0] == m_val);
    for (int k = 0; k < 3; k++)
      if (hit[k]) m_irq[k] = 1'b1; else if (clr[k]) m_irq[k] = 1'b0;
    if (wr && ws <= 3'd1) begin
      m_val = wd[62:0] + 63'(inc);
      m_top = wd[63];
    end else begin
      m_val = m_val + 63'(inc);
    end
    if (wr && ws >= 3'd2 && ws <= 3'd4) m_cmp[ws - 3'd2] = wd;
    @(posedge clk);
    @(negedge clk);
    check({tag, " rd_data"}, rd_data, erd);
    check({tag, " irq"}, {61'd0, irq}, {61'd0, m_irq});
    tick_inc = 0; wr_en = 0; irq_clr = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; tick_inc = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0; irq_clr = 0;
    m_val = 0; m_top = 1; m_irq = 0;
    for (int k = 0; k < 3; k++) m_cmp[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rd_data in reset", rd_data, 64'd0);
    check("R1 irq in reset", {61'd0, irq}, 64'd0);
    rst = 0;
    step(0, 0, 0, 0, 3'd0, 0, "R1 reset tick");
    check("R1 reset tick literal", rd_data, 64'h8000_0000_0000_0000);
    step(0, 0, 0, 0, 3'd2, 0, "R6 reset cmp0");
    step(0, 0, 0, 0, 3'd4, 0, "R6 reset cmp2");
    step(1, 0, 0, 0, 3'd0, 3'd7, "R9 match beats clear");
    step(0, 0, 0, 0, 3'd0, 3'd7, "R9 clear");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 3'd0, 0, "R2 increment");
    step(0, 1, 3'd1, 64'h1234_5678_9abc_def3, 3'd0, 0, "R5 stick write");
    step(0, 0, 0, 0, 3'd0, 0, "R5 read via tick");
    check("R4 masked low bits", rd_data, 64'h1234_5678_9abc_def0);
    step(1, 1, 3'd0, 64'h0000_0000_0000_0100, 3'd1, 0, "R3 write with inc");
    step(0, 0, 0, 0, 3'd1, 0, "R3 read back");
    check("R3 write plus inc value", rd_data, 64'h0000_0000_0000_0100);
    step(0, 1, 3'd0, 64'h7fff_ffff_ffff_ffff, 3'd0, 0, "R2 wrap setup");
    step(1, 0, 0, 0, 3'd0, 0, "R2 wrap inc");
    step(0, 0, 0, 0, 3'd0, 0, "R2 wrap read");
    check("R2 wrap value", rd_data, 64'd0);
    step(0, 1, 3'd2, 64'd3, 3'd2, 0, "R6 cmp0 write");
    step(0, 1, 3'd3, 64'h8000_0000_0000_0002, 3'd2, 0, "R6 cmp1 write");
    step(0, 0, 0, 0, 3'd3, 0, "R6 cmp1 read");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 3'd0, 0, "R7 R8 count to match");
    step(0, 0, 0, 0, 3'd0, 3'd7, "R9 clear after match");
    step(0, 1, 3'd5, 64'hdead_beef_0000_0000, 3'd5, 0, "R10 unused write");
    step(0, 0, 0, 0, 3'd5, 0, "R10 unused read");
    step(0, 0, 0, 0, 3'd0, 0, "R10 state unchanged");
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  ws;
      logic [63:0] wd;
      ws = 3'($urandom % 8);
      if (ws >= 3'd2 && ws <= 3'd4)
        wd = {($urandom % 4) == 0, m_val + 63'($urandom % 8)};
      else
        wd = {$urandom, $urandom};
      step(1'($urandom % 2), ($urandom % 4) == 0, ws, wd, 3'($urandom % 8),
           (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'd0, "R4 R7 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule